// File: doc/BRIEF.md
# Audio Bit-Clock and Master-Clock Generator

This block derives the serial bit clock and an optional oversampling master clock for a stereo audio serial port from a single reference clock. A linear 8-bit divider value and an odd-extension flag together form a divide ratio. When the master clock output is off, that ratio is the bit-clock period in reference cycles. When it is on, the ratio sets the master clock period, and the bit clock is a fixed fraction of the master clock. The fraction is chosen so that the master clock always runs at 256 times the sample rate, whether a channel slot is 16 or 32 bits wide.

Next to the two clocks, the block drives single-cycle strobes, aligned to the reference clock, that mark the leading and trailing edges of the bit clock and the first bit of each stereo frame. A serializer can advance its shift register on these strobes without sampling the generated clock. Configuration written while the generator runs is held back until the current stereo frame ends, so the bit clock never shows a runt pulse. When the generator is disabled, the bit clock rests at a programmable idle level.

Top module: `audio_clkgen`

## Requirements
- R1: With master clock off, the divide ratio is N = 2*D + odd, where D is the divider value. The bit clock repeats every N reference cycles. After each leading edge it is away from idle for floor(N/2) cycles and at idle for the rest.
- R2: Divider values 0 and 1 act exactly like a divider value of 2.
- R3: With master clock on, mclk repeats every N cycles and is high for the first floor(N/2) of them. With master clock off, mclk stays low.
- R4: With master clock on, the bit-clock period is 8*N cycles for 16-bit slots (frame32=0) and 4*N cycles for 32-bit slots (frame32=1). In each case the bit clock is away from idle for the first half of the period.
- R5: The idle level of the bit clock is ck_idle_hi (1 = idle high). The first leading edge, meaning the move away from idle, appears one cycle after the first rising clock edge at which en is sampled high.
- R6: ck_lead is high exactly in the cycles where ck has just left idle. ck_trail is high exactly in the cycles where ck has just returned to idle.
- R7: frame_stb pulses with the leading edge of the first bit-clock period after enable, and again every 32 (frame32=0) or 64 (frame32=1) bit-clock periods after that.
- R8: A change to div, odd, mclk_en, frame32 or ck_idle_hi while en is high takes effect only from the first period of the next stereo frame.
- R9: One cycle after en is sampled low, ck equals ck_idle_hi, mclk is low and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator run enable |
| div | input | 8 | Linear divider value D |
| odd | input | 1 | Adds one reference cycle to the ratio (N = 2*D + odd) |
| mclk_en | input | 1 | Enables the master clock output and the master-clock bit-clock mode |
| frame32 | input | 1 | Channel slot width: 0 = 16 bits, 1 = 32 bits |
| ck_idle_hi | input | 1 | Bit-clock idle level |
| ck | output | 1 | Bit clock |
| mclk | output | 1 | Master clock |
| ck_lead | output | 1 | Strobe: ck has just left idle |
| ck_trail | output | 1 | Strobe: ck has just returned to idle |
| frame_stb | output | 1 | Strobe: first bit-clock period of a stereo frame |

## Verification
All outputs are registered. After the first rising edge at which en is high, the value seen in cycle t belongs to ratio position t. The bench therefore counts t from the first falling edge after enable and compares every output against an arithmetic model of that position, sampling on falling edges. Idle and disable results are due one edge after en falls and are checked at the next falling edge. For a mid-run configuration change, the model switches to the new setting at cycle t equal to the old frame length (N*M*32 or N*M*64), and every cycle on both sides of that point is compared.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  input  logic             mclk_en,
  input  logic             frame32,
  input  logic             ck_idle_hi,
  output logic             ck,
  output logic             mclk,
  output logic             ck_lead,
  output logic             ck_trail,
  output logic             frame_stb
);
  localparam int RW = DIV_W + 1;
  localparam int BW = 6;

  logic [DIV_W-1:0] a_div;
  logic             a_odd, a_mclk, a_f32, a_pol;
  logic [RW-1:0]    mcnt;
  logic [2:0]       sub;
  logic [BW-1:0]    bcnt;

  wire [DIV_W-1:0] div_eff = (a_div < DIV_W'(2)) ? DIV_W'(2) : a_div;
  wire [RW-1:0]    ratio   = {div_eff, 1'b0} + RW'(a_odd);
  wire [3:0]       mult    = !a_mclk ? 4'd1 : (a_f32 ? 4'd4 : 4'd8);
  wire [3:0]       sub_w   = {1'b0, sub};

  wire m_last = (mcnt == ratio - RW'(1));
  wire s_last = (sub_w == mult - 4'd1);
  wire b_last = (bcnt == (a_f32 ? BW'(63) : BW'(31)));
  wire p_last = m_last && s_last;
  wire f_last = p_last && b_last;

  wire m_high  = (mcnt < (ratio >> 1));
  wire ck_act  = a_mclk ? (sub_w < (mult >> 1)) : m_high;
  wire at_lead = (mcnt == '0) && (sub == '0);
  wire at_trl  = a_mclk ? ((mcnt == '0) && (sub_w == (mult >> 1)))
                        : (mcnt == (ratio >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div <= DIV_W'(2); a_odd <= 1'b0; a_mclk <= 1'b0; a_f32 <= 1'b0; a_pol <= 1'b0;
      mcnt <= '0; sub <= '0; bcnt <= '0;
      ck <= 1'b0; mclk <= 1'b0; ck_lead <= 1'b0; ck_trail <= 1'b0; frame_stb <= 1'b0;
    end else if (!en) begin
      a_div <= div; a_odd <= odd; a_mclk <= mclk_en; a_f32 <= frame32; a_pol <= ck_idle_hi;
      mcnt <= '0; sub <= '0; bcnt <= '0;
      ck <= ck_idle_hi; mclk <= 1'b0; ck_lead <= 1'b0; ck_trail <= 1'b0; frame_stb <= 1'b0;
    end else begin
      ck        <= a_pol ^ ck_act;
      mclk      <= a_mclk && m_high;
      ck_lead   <= at_lead;
      ck_trail  <= at_trl;
      frame_stb <= at_lead && (bcnt == '0);
      mcnt <= m_last ? '0 : mcnt + RW'(1);
      if (m_last) sub <= s_last ? '0 : sub + 3'd1;
      if (p_last) bcnt <= b_last ? '0 : bcnt + BW'(1);
      if (f_last) begin
        a_div <= div; a_odd <= odd; a_mclk <= mclk_en; a_f32 <= frame32; a_pol <= ck_idle_hi;
      end
    end
  end

  a_r6_lead_active: assert property (@(posedge clk) disable iff (!rst_n)
    ck_lead |-> (ck != a_pol));
  a_r6_trail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ck_trail |-> (ck == a_pol));
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ck_lead, ck_trail}));
  a_r7_frame_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> ck_lead);
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!mclk && !ck_lead && !ck_trail && !frame_stb));
  a_r3_mclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !a_mclk) |=> !mclk);
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !f_last) |=> $stable({a_div, a_odd, a_mclk, a_f32, a_pol}));
endmodule

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] div = 8'd2;
  logic odd = 1'b0, mclk_en = 1'b0, frame32 = 1'b0, ck_idle_hi = 1'b0;
  logic ck, mclk, ck_lead, ck_trail, frame_stb;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_clkgen uut (.clk(clk), .rst_n(rst_n), .en(en), .div(div), .odd(odd),
    .mclk_en(mclk_en), .frame32(frame32), .ck_idle_hi(ck_idle_hi), .ck(ck), .mclk(mclk),
    .ck_lead(ck_lead), .ck_trail(ck_trail), .frame_stb(frame_stb));

  function automatic int ratio_of(int d, bit o);
    return 2 * ((d < 2) ? 2 : d) + int'(o);
  endfunction
  function automatic int mult_of(bit mc, bit f32);
    return !mc ? 1 : (f32 ? 4 : 8);
  endfunction
  // returns {ck, mclk, lead, trail, frame}
  function automatic logic [4:0] model(int r, bit mc, bit f32, bit pol, int t);
    int m = mult_of(mc, f32);
    int per = r * m;
    int fb = f32 ? 64 : 32;
    int p = t % per;
    logic a = (p < per / 2);
    return {pol ^ a, mc && ((p % r) < r / 2), p == 0, p == per / 2, (t % (per * fb)) == 0};
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (ck,mclk,lead,trail,frame)", tag, act, exp);
    end
  endtask

  task automatic setcfg(int d, bit o, bit mc, bit f32, bit pol);
    div = 8'(d); odd = o; mclk_en = mc; frame32 = f32; ck_idle_hi = pol;
  endtask

  task automatic run_cfg(int d, bit o, bit mc, bit f32, bit pol, int len);
    string tag;
    @(negedge clk);
    en = 1'b0; setcfg(d, o, mc, f32, pol);
    @(negedge clk);
    check("R9 R5 idle", {ck, mclk, ck_lead, ck_trail, frame_stb}, {pol, 4'b0000});
    en = 1'b1;
    tag = mc ? "R4 R3 R6 R7" : ((d < 2) ? "R2 R1 R3 R6 R7" : "R1 R3 R6 R7");
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      check(tag, {ck, mclk, ck_lead, ck_trail, frame_stb}, model(ratio_of(d, o), mc, f32, pol, t));
    end
    en = 1'b0; ck_idle_hi = ~pol;
    @(negedge clk);
    check("R9 disable", {ck, mclk, ck_lead, ck_trail, frame_stb}, {~pol, 4'b0000});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int fold;
    @(negedge clk);
    check("R9 reset", {ck, mclk, ck_lead, ck_trail, frame_stb}, 5'b00000);
    rst_n = 1'b1;

    for (int di = 0; di < 6; di++) begin
      int d = (di < 4) ? di : 2 * di - 3;
      for (int k = 0; k < 16; k++) begin
        int r = ratio_of(d, k[0]);
        run_cfg(d, k[0], k[1], k[2], k[3], 4 * r * mult_of(k[1], k[2]));
      end
    end
    // R1/R3/R4 at the top of the divider range
    run_cfg(255, 1'b1, 1'b0, 1'b0, 1'b1, 1100);
    run_cfg(255, 1'b0, 1'b1, 1'b1, 1'b0, 4200);
    // R7 frame repetition
    run_cfg(2, 1'b0, 1'b0, 1'b1, 1'b0, 640);
    run_cfg(2, 1'b1, 1'b1, 1'b0, 1'b1, 5 * 8 * 32 + 100);

    // R8: change settings mid frame, expect effect at frame boundary only
    @(negedge clk);
    en = 1'b0; setcfg(2, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    en = 1'b1;
    fold = 4 * 32;
    for (int t = 0; t < fold + 6 * 32 + 40; t++) begin
      @(negedge clk);
      if (t == 10) setcfg(3, 1'b0, 1'b0, 1'b0, 1'b1);
      if (t < fold)
        check("R8 old", {ck, mclk, ck_lead, ck_trail, frame_stb}, model(4, 1'b0, 1'b0, 1'b0, t));
      else
        check("R8 new", {ck, mclk, ck_lead, ck_trail, frame_stb}, model(6, 1'b0, 1'b0, 1'b1, t - fold));
    end
    // R8: master clock switched on mid frame
    @(negedge clk);
    en = 1'b0; setcfg(2, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    en = 1'b1;
    for (int t = 0; t < fold + 300; t++) begin
      @(negedge clk);
      if (t == 50) setcfg(2, 1'b1, 1'b1, 1'b1, 1'b0);
      if (t < fold)
        check("R8 mclk old", {ck, mclk, ck_lead, ck_trail, frame_stb}, model(4, 1'b0, 1'b0, 1'b0, t));
      else
        check("R8 mclk new", {ck, mclk, ck_lead, ck_trail, frame_stb}, model(5, 1'b1, 1'b1, 1'b0, t - fold));
    end
    en = 1'b0;
    @(negedge clk);
    check("R9 final", {ck, mclk, ck_lead, ck_trail, frame_stb}, {ck_idle_hi, 4'b0000});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule